// File: doc/BRIEF.md
# Isochronous Transmit Header Inserter

This block builds isochronous packets for a serial-bus link transmitter. Each packet is one header quadlet followed by a programmed number of payload quadlets. The header comes from one of two places, chosen per packet:

- **Automatic mode:** the host preloads the header register through a small write port.
- **Manual mode:** the header is the first quadlet pulled from the streaming data-mover port.

Quadlets leave through a registered valid/ready interface toward the transmitter. The last quadlet of a packet is flagged.

Toward the external data source the block raises a pre-request strobe. The source may present its first quadlet one cycle after it sees that strobe. The strobe stays up until every quadlet the packet needs has been accepted. Upstream quadlets are taken with a valid/ready pair. The source holds a quadlet until it is accepted, and the block accepts a quadlet only when its one-quadlet output register is free. A transmitter stall therefore propagates back to the source without losing or duplicating data.

Top module: `iso_hdr_inserter`

## Requirements
- R1: A synchronous active-high reset clears `tx_valid`, `tx_last`, `pre_req`, `busy` and `dm_ready`, and zeroes the header register. An automatic packet started after reset with no host write therefore sends header 0.
- R2: In automatic mode (`cfg_manual`=0), a host write with `host_addr`=0x38 while idle loads the header register. A `start` pulse then sends that header first, followed by `cfg_len` payload quadlets taken from `dm_data` in acceptance order.
- R3: In manual mode (`cfg_manual`=1), the first quadlet accepted from the data port is sent as the header and also replaces the header register contents. The next `cfg_len` accepted quadlets follow as payload. A later automatic packet with no new host write sends this captured header.
- R4: Each packet puts out exactly `cfg_len`+1 quadlets. `tx_last` is high only with `tx_valid`, and only on the final quadlet. When `cfg_len`=0, `tx_last` is high on the header.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values. No quadlet is lost or sent twice.
- R6: `pre_req` is high from the cycle after an accepted `start`, provided the packet needs any data-port quadlet. It stays high until the last needed quadlet is accepted, then falls. `dm_ready` is never high while `pre_req` is low.
- R7: In the second cycle after the `start` edge (the cycle after `pre_req` is first seen high), `dm_ready` is high if the transmitter has held `tx_ready` high.
- R8: `busy` is high from the cycle after an accepted `start` until the final quadlet has been handed off. While `busy` is high, `start` and host writes to 0x38 are ignored. Writes to any other address are ignored at all times.
- R9: `cfg_manual` and `cfg_len` are sampled only with an accepted `start`. Changing them during a packet does not alter its length, its mode, or the header register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW (8) | Host write address; header register at 0x38 |
| host_wdata | input | QW (32) | Host write data |
| cfg_manual | input | 1 | 1 = header from data port, 0 = header from host register |
| cfg_len | input | LEN_W (12) | Payload length in quadlets |
| start | input | 1 | Packet start strobe, taken only when idle |
| busy | output | 1 | Packet in progress |
| pre_req | output | 1 | Pre-request to the external data source |
| dm_valid | input | 1 | Data-port quadlet present |
| dm_data | input | QW (32) | Data-port quadlet |
| dm_ready | output | 1 | Data-port quadlet accepted this cycle when valid |
| tx_valid | output | 1 | Quadlet valid toward the transmitter |
| tx_data | output | QW (32) | Quadlet toward the transmitter |
| tx_last | output | 1 | Final quadlet of the packet |
| tx_ready | input | 1 | Transmitter accepts the quadlet |

## Verification
The checker assumes that the data source raises `dm_valid` only in a cycle after it has seen `pre_req` high, and that it keeps a presented quadlet steady until it is accepted. The stimulus enforces both rules: the source model gates its valid with the previous cycle's `pre_req` and remembers a pending quadlet. The bench also assumes that `start` and a host write to 0x38 never arrive in the same idle cycle, and its tasks always separate them. Random `start` pulses, header writes and configuration changes are injected only while `busy` is high, where they must have no effect.

// File: rtl/iso_tx_pkg.sv
`timescale 1ns/1ps
package iso_tx_pkg;
  localparam int QUAD_W = 32;
  localparam int ADDR_W = 8;
  localparam int LENGTH_W = 12;
  localparam logic [ADDR_W-1:0] HDR_REG_ADDR = 8'h38;
endpackage

// File: rtl/iso_hdr_reg.sv
`timescale 1ns/1ps
// Header register: loaded by a host write while idle, or by capture of the
// first data-port quadlet in manual mode. Capture takes priority.
module iso_hdr_reg #(
  parameter int QW = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] HDR_ADDR = 8'h38
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [QW-1:0] wdata,
  input  logic          cap_en,
  input  logic [QW-1:0] cap_data,
  output logic [QW-1:0] hdr
);
  logic host_hit;
  assign host_hit = wr_en && !busy && (addr == HDR_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr <= '0;
    end else if (cap_en) begin
      hdr <= cap_data;
    end else if (host_hit) begin
      hdr <= wdata;
    end
  end
endmodule

// File: rtl/iso_tx_ctrl.sv
`timescale 1ns/1ps
// Packet sequencer: samples the mode and length at start, counts quadlets,
// drives the pre-request, the upstream ready and the output-register loads.
module iso_tx_ctrl #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cfg_manual,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             dm_valid,
  input  logic             out_vld,
  input  logic             tx_ready,
  output logic             busy,
  output logic             pre_req,
  output logic             dm_ready,
  output logic             load_en,
  output logic             load_hdr,
  output logic             load_last,
  output logic             cap_en
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] rem_q, rem_d;
  logic need_q, need_d;
  logic busy_d, pre_d, vld_d;
  logic free, start_ok, words_left, words_left_d, fire;

  always_comb begin
    free       = !out_vld || tx_ready;
    start_ok   = !busy && start;
    words_left = need_q || (rem_q != '0);
    dm_ready   = busy && words_left && free;
    fire       = dm_ready && dm_valid;
    cap_en     = fire && need_q;
    load_hdr   = start_ok && !cfg_manual;
    load_en    = load_hdr || fire;

    need_d    = need_q;
    rem_d     = rem_q;
    load_last = 1'b0;
    if (start_ok) begin
      need_d    = cfg_manual;
      rem_d     = cfg_len;
      load_last = (cfg_len == '0);
    end else if (fire) begin
      if (need_q) begin
        need_d    = 1'b0;
        load_last = (rem_q == '0);
      end else begin
        rem_d     = rem_q - ONE;
        load_last = (rem_q == ONE);
      end
    end

    words_left_d = need_d || (rem_d != '0);
    vld_d        = load_en || (out_vld && !tx_ready);
    if (start_ok) begin
      busy_d = 1'b1;
      pre_d  = cfg_manual || (cfg_len != '0);
    end else begin
      busy_d = busy && (words_left_d || vld_d);
      pre_d  = busy && words_left_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      need_q  <= 1'b0;
      busy    <= 1'b0;
      pre_req <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      need_q  <= need_d;
      busy    <= busy_d;
      pre_req <= pre_d;
    end
  end
endmodule

// File: rtl/iso_tx_outreg.sv
`timescale 1ns/1ps
// One-quadlet registered output stage toward the transmitter.
module iso_tx_outreg #(
  parameter int QW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [QW-1:0] load_data,
  input  logic          load_last,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [QW-1:0] tx_data,
  output logic          tx_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
    end else if (load_en) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
      tx_last  <= load_last;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/iso_hdr_inserter.sv
`timescale 1ns/1ps
module iso_hdr_inserter
  import iso_tx_pkg::*;
#(
  parameter int QW = QUAD_W,
  parameter int AW = ADDR_W,
  parameter int LEN_W = LENGTH_W,
  parameter logic [AW-1:0] HDR_ADDR = HDR_REG_ADDR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_addr,
  input  logic [QW-1:0]    host_wdata,
  input  logic             cfg_manual,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             start,
  output logic             busy,
  output logic             pre_req,
  input  logic             dm_valid,
  input  logic [QW-1:0]    dm_data,
  output logic             dm_ready,
  output logic             tx_valid,
  output logic [QW-1:0]    tx_data,
  output logic             tx_last,
  input  logic             tx_ready
);
  logic [QW-1:0] hdr;
  logic [QW-1:0] load_data;
  logic load_en, load_hdr, load_last, cap_en;

  iso_tx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cfg_manual(cfg_manual),
    .cfg_len(cfg_len), .dm_valid(dm_valid), .out_vld(tx_valid),
    .tx_ready(tx_ready), .busy(busy), .pre_req(pre_req),
    .dm_ready(dm_ready), .load_en(load_en), .load_hdr(load_hdr),
    .load_last(load_last), .cap_en(cap_en)
  );

  iso_hdr_reg #(.QW(QW), .AW(AW), .HDR_ADDR(HDR_ADDR)) u_hdr (
    .clk(clk), .rst(rst), .busy(busy), .wr_en(host_wr),
    .addr(host_addr), .wdata(host_wdata), .cap_en(cap_en),
    .cap_data(dm_data), .hdr(hdr)
  );

  assign load_data = load_hdr ? hdr : dm_data;

  iso_tx_outreg #(.QW(QW)) u_out (
    .clk(clk), .rst(rst), .load_en(load_en), .load_data(load_data),
    .load_last(load_last), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last)
  );
endmodule

// File: rtl/iso_hdr_inserter_chk.sv
`timescale 1ns/1ps
module iso_hdr_inserter_chk #(
  parameter int QW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          pre_req,
  input logic          dm_valid,
  input logic          dm_ready,
  input logic          tx_valid,
  input logic [QW-1:0] tx_data,
  input logic          tx_last,
  input logic          tx_ready
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!tx_valid && !pre_req && !busy && !tx_last)); // R1
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R5
  AST_READY_NEEDS_PREREQ: assert property (@(posedge clk) disable iff (rst)
    dm_ready |-> pre_req); // R6
  AST_PREREQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (pre_req && !(dm_valid && dm_ready)) |=> pre_req); // R6
  AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !dm_ready); // R8
endmodule

bind iso_hdr_inserter iso_hdr_inserter_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .pre_req(pre_req),
  .dm_valid(dm_valid), .dm_ready(dm_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
);

// File: tb/iso_hdr_inserter_tb.sv
`timescale 1ns/1ps
module iso_hdr_inserter_tb;
  localparam int QW = 32;
  localparam int AW = 8;
  localparam int LEN_W = 12;
  localparam logic [AW-1:0] HA = 8'h38;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [QW-1:0] host_wdata = '0;
  logic cfg_manual = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic start = 1'b0;
  logic busy, pre_req, dm_ready, tx_valid, tx_last;
  logic dm_valid = 1'b0;
  logic [QW-1:0] dm_data = '0;
  logic [QW-1:0] tx_data;
  logic tx_ready = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [QW-1:0] hdr_m = '0;
  logic [QW-1:0] expq[$];

  iso_hdr_inserter u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .cfg_manual(cfg_manual), .cfg_len(cfg_len),
    .start(start), .busy(busy), .pre_req(pre_req), .dm_valid(dm_valid),
    .dm_data(dm_data), .dm_ready(dm_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [QW-1:0] act, input logic [QW-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [QW-1:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    if (a == HA) hdr_m = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic run_pkt(input bit manual, input int len, input int rdy_pct, input int vld_pct, input bit noise);
    bit prev_pre = 1'b0;
    bit pend = 1'b0;
    bit stall_prev = 1'b0;
    bit done = 1'b0;
    logic [QW-1:0] sd = '0;
    logic sl = 1'b0;
    int acc = 0;
    int txc = 0;
    bit need = manual || (len != 0);
    @(negedge clk);
    cfg_manual = manual; cfg_len = LEN_W'(len); start = 1'b1;
    tx_ready = 1'b1; dm_valid = 1'b0;
    expq.delete();
    if (!manual) expq.push_back(hdr_m);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (cyc > 0 && !busy) begin done = 1'b1; break; end
      start = 1'b0;
      tx_ready = (cyc < 2) ? 1'b1 : (($urandom % 100) < rdy_pct);
      if (!pend) begin
        dm_valid = prev_pre && (($urandom % 100) < vld_pct);
        if (dm_valid) dm_data = $urandom;
      end
      if (noise && cyc > 0) begin
        host_wr = ($urandom % 4) == 0; host_addr = HA; host_wdata = $urandom;
        start = ($urandom % 5) == 0;
        cfg_manual = $urandom; cfg_len = LEN_W'($urandom);
      end
      #1;
      if (cyc == 0) begin
        chk(busy == 1'b1, "R8 busy after start", QW'(busy), 1);
        chk(pre_req == need, "R6 pre_req after start", QW'(pre_req), QW'(need));
      end
      if (cyc == 1)
        chk(dm_ready == need, "R7 dm_ready one cycle after pre_req", QW'(dm_ready), QW'(need));
      if (dm_ready)
        chk(pre_req, "R6 dm_ready without pre_req", QW'(pre_req), 1);
      if (stall_prev)
        chk(tx_valid && tx_data == sd && tx_last == sl, "R5 stall hold", tx_data, sd);
      stall_prev = tx_valid && !tx_ready;
      sd = tx_data; sl = tx_last;
      if (dm_valid && dm_ready) begin
        if (manual && acc == 0) hdr_m = dm_data;
        expq.push_back(dm_data);
        acc++;
        pend = 1'b0;
      end else begin
        pend = dm_valid;
      end
      if (tx_valid && tx_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4 extra quadlet", tx_data, 0);
        end else begin
          logic [QW-1:0] e = expq.pop_front();
          chk(tx_data == e, manual ? "R3 manual quadlet" : "R2 auto quadlet", tx_data, e);
        end
        chk(tx_last == (txc == len), "R4 last flag", QW'(tx_last), QW'(txc == len));
        txc++;
      end
      prev_pre = pre_req;
    end
    host_wr = 1'b0; start = 1'b0; dm_valid = 1'b0; pend = 1'b0;
    chk(done, "R8 busy falls at packet end", QW'(done), 1);
    chk(txc == len + 1, "R9 quadlet count", QW'(txc), QW'(len + 1));
    chk(acc == len + int'(manual), "R3 data-port accepts", QW'(acc), QW'(len + int'(manual)));
    chk(!pre_req && !tx_valid && !dm_ready, "R6 idle after packet", QW'({pre_req, tx_valid, dm_ready}), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!tx_valid && !pre_req && !busy && !dm_ready && !tx_last, "R1 reset outputs",
        QW'({tx_valid, pre_req, busy, dm_ready, tx_last}), 0);
    run_pkt(1'b0, 2, 100, 100, 1'b0);                // R1: header is 0 after reset
    host_write(HA, 32'hCAFE_0138);
    run_pkt(1'b0, 4, 100, 100, 1'b0);                // R2
    run_pkt(1'b1, 3, 100, 100, 1'b0);                // R3
    run_pkt(1'b0, 0, 100, 100, 1'b0);                // R4: header carries last
    run_pkt(1'b1, 0, 50, 100, 1'b0);                 // R4 manual, no payload
    host_write(8'h3C, 32'h1111_2222);                // R8: other address ignored
    run_pkt(1'b0, 1, 100, 100, 1'b0);                // R3: captured header reused
    run_pkt(1'b0, 6, 30, 60, 1'b0);                  // R5 heavy stalls
    host_write(HA, 32'h0BAD_F00D);
    run_pkt(1'b0, 5, 70, 70, 1'b1);                  // R8/R9 noise while busy
    run_pkt(1'b0, 2, 100, 100, 1'b0);                // R8: header unchanged by busy writes
    for (int i = 0; i < 30; i++) begin
      if ($urandom % 2) host_write(HA, $urandom);
      run_pkt(1'($urandom), int'($urandom % 9), 40 + int'($urandom % 61), 40 + int'($urandom % 61), 1'($urandom));
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hdr_m = '0;
    run_pkt(1'b0, 1, 100, 100, 1'b0);                // R1: reset clears header
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule